// File: doc/BRIEF.md
# Hardware Return Address Stack

This block keeps the return addresses of a processor core in dedicated storage next to the fetch logic. When the core executes a subroutine call or accepts an interrupt, it raises the push strobe with the current program counter on the PC input. When it executes a return-type instruction, it raises the pop strobe. The saved address appears on the PC output in that same cycle.

The stack holds 31 entries of 21 bits each. A 5-bit pointer addresses them, and valid data sits at pointer values 1 through 31. Pointer value 0 means the stack is empty and has no storage behind it. A push first moves the pointer up and then writes the new slot. A pop reads the current slot and then moves the pointer down. Two sticky flags record a push into a full stack and a pop from an empty stack. The flags stay set until the next reset. The reset input is asynchronous and active low, and the block releases it internally on a clock edge.

Top module: `ret_stack`

## Requirements
- R1: After reset the pointer output is 0, the full, overflow and underflow flags are 0, and the PC output is 0.
- R2: A push with the pointer below 31 raises the pointer by exactly one at the next edge, and from then on the PC output shows the pushed value.
- R3: A pop with the pointer above 0 presents the top entry on the PC output in the cycle the pop is held, and lowers the pointer by exactly one at the next edge.
- R4: Any sequence of up to 31 pushes followed by pops returns the pushed values in reverse order.
- R5: A push while the pointer is 31 sets the overflow flag, leaves the pointer at 31 and leaves every stored entry unchanged, so the top still shows the 31st value.
- R6: A pop while the pointer is 0 sets the underflow flag, leaves the pointer at 0, and the PC output reads 0.
- R7: When push and pop are asserted in the same cycle, only the push takes effect.
- R8: The overflow and underflow flags, once set, stay set through any later pushes and pops and clear only on reset.
- R9: The full flag is 1 exactly when the pointer equals 31.
- R10: Whenever the pointer is 0 the PC output is 0, including after data has been pushed and popped again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_i | input | 1 | Save pc_i on the stack (call or interrupt acknowledge) |
| pop_i | input | 1 | Remove the top entry (return-type instruction) |
| pc_i | input | 21 | Program counter value to save |
| pc_o | output | 21 | Top-of-stack value, 0 when empty |
| sp_o | output | 5 | Current stack pointer |
| full_o | output | 1 | Pointer is at the last entry |
| ovf_o | output | 1 | Sticky: a push was made while full |
| unf_o | output | 1 | Sticky: a pop was made while empty |

## Verification
The hardest state to reach from the ports is an overflowing push. It needs 31 consecutive successful pushes first, and afterwards the bench must confirm that the rejected push changed no slot at all. The bench fills the stack with 31 distinct computed values and checks the full flag at depths 30 and 31. It then pushes once more and drains all 31 entries, comparing each against the expected reverse order. An intact bottom-to-top sequence shows that the rejected write landed nowhere. The sticky flags are then exercised across further traffic, and finally a reset clears them.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  localparam int unsigned RSTK_PC_W  = 21;
  localparam int unsigned RSTK_DEPTH = 31;

  typedef enum logic [1:0] {
    RSTK_IDLE = 2'd0,
    RSTK_PUSH = 2'd1,
    RSTK_POP  = 2'd2
  } rstk_op_e;

  // push outranks pop when both strobes are high
  function automatic rstk_op_e rstk_decode(input logic push, input logic pop);
    if (push)     return RSTK_PUSH;
    else if (pop) return RSTK_POP;
    else          return RSTK_IDLE;
  endfunction
endpackage

// File: rtl/rstk_rst_sync.sv
module rstk_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sn
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sn = sync_q;
endmodule

// File: rtl/rstk_ptr_ctrl.sv
module rstk_ptr_ctrl
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH = RSTK_DEPTH,
  parameter int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] sp,
  output logic             full,
  output logic             ovf,
  output logic             unf,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr
);
  localparam logic [PTR_W-1:0] TOP  = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);
  localparam logic [PTR_W-1:0] ZERO = '0;

  rstk_op_e         op;
  logic [PTR_W-1:0] sp_q, sp_d;
  logic             ovf_q, ovf_d;
  logic             unf_q, unf_d;
  logic             sp_en;

  always_comb begin
    op      = rstk_decode(push, pop);
    sp_d    = sp_q;
    ovf_d   = ovf_q;
    unf_d   = unf_q;
    wr_en   = 1'b0;
    wr_addr = sp_q + ONE;
    unique case (op)
      RSTK_PUSH: begin
        if (sp_q == TOP) begin
          ovf_d = 1'b1;
        end else begin
          sp_d  = sp_q + ONE;
          wr_en = 1'b1;
        end
      end
      RSTK_POP: begin
        if (sp_q == ZERO) unf_d = 1'b1;
        else              sp_d  = sp_q - ONE;
      end
      default: ;
    endcase
    sp_en = (op != RSTK_IDLE);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sp_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (sp_en) begin
      sp_q  <= sp_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign sp   = sp_q;
  assign ovf  = ovf_q;
  assign unf  = unf_q;
  assign full = (sp_q == TOP);

  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (push && sp != TOP) |=> (sp == $past(sp) + ONE));
  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (pop && !push && sp != ZERO) |=> (sp == $past(sp) - ONE));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (push && sp == TOP) |=> (sp == TOP && ovf));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (pop && !push && sp == ZERO) |=> (sp == ZERO && unf));
  assert_push_wins_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (push && pop && sp != TOP) |=> (sp != ZERO));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    ovf |=> ovf);
  assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    unf |=> unf);
endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
  parameter int unsigned DEPTH = 31,
  parameter int unsigned PC_W  = 21,
  parameter int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [PC_W-1:0]  wr_data,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [PC_W-1:0]  rd_data
);
  logic [PC_W-1:0] slot_q [1:DEPTH];

  // slot 0 does not exist: address 0 is the empty marker
  for (genvar g = 1; g <= DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_addr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 1; k <= int'(DEPTH); k++) begin
      if (rd_addr == PTR_W'(k)) rd_data = slot_q[k];
    end
  end

  assert_write_in_range_R5: assert property (@(posedge clk)
    wr_en |-> (wr_addr != '0 && int'(wr_addr) <= int'(DEPTH)));
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import rstk_pkg::*;
#(
  parameter int unsigned PC_W  = RSTK_PC_W,
  parameter int unsigned DEPTH = RSTK_DEPTH,
  localparam int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PTR_W-1:0] sp_o,
  output logic             full_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic             rst_sn;
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr;
  logic [PTR_W-1:0] sp;

  rstk_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_sn (rst_sn)
  );

  rstk_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .push    (push_i),
    .pop     (pop_i),
    .sp      (sp),
    .full    (full_o),
    .ovf     (ovf_o),
    .unf     (unf_o),
    .wr_en   (wr_en),
    .wr_addr (wr_addr)
  );

  rstk_store #(.DEPTH(DEPTH), .PC_W(PC_W), .PTR_W(PTR_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (pc_i),
    .rd_addr (sp),
    .rd_data (pc_o)
  );

  assign sp_o = sp;

  assert_empty_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (sp_o == '0) |-> (pc_o == '0));
  assert_top_after_push_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (push_i && !full_o) |=> (pc_o == $past(pc_i)));
endmodule

// File: tb/ret_stack_bench.sv
module ret_stack_bench;
  localparam int PC_W  = 21;
  localparam int DEPTH = 31;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            push_i, pop_i;
  logic [PC_W-1:0] pc_i;
  logic [PC_W-1:0] pc_o;
  logic [4:0]      sp_o;
  logic            full_o, ovf_o, unf_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ret_stack u_ret_stack (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .pc_i(pc_i),
    .pc_o(pc_o), .sp_o(sp_o), .full_o(full_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  function automatic logic [PC_W-1:0] val(input int i);
    return PC_W'((i * 32'h0001_2345 + 32'h7) & 32'h1F_FFFF);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // inputs change on falling edges; outputs sampled just before the rising edge
  task automatic step(input logic ps, input logic pp, input logic [PC_W-1:0] d);
    @(negedge clk);
    push_i = ps; pop_i = pp; pc_i = d;
  endtask

  task automatic idle();
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; push_i = 1'b0; pop_i = 1'b0; pc_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 sp",   32'(sp_o),   0);
    chk("R1 full", 32'(full_o), 0);
    chk("R1 ovf",  32'(ovf_o),  0);
    chk("R1 unf",  32'(unf_o),  0);
    chk("R1 pc",   32'(pc_o),   0);
  endtask

  task automatic t_push_pop();
    step(1, 0, 21'h0ABCDE); idle();
    chk("R2 sp", 32'(sp_o), 1);
    chk("R2 top", 32'(pc_o), 32'h0ABCDE);
    step(1, 0, 21'h1F0F0F); idle();
    chk("R2 sp2", 32'(sp_o), 2);
    step(0, 1, '0); #1;
    chk("R3 pop data", 32'(pc_o), 32'h1F0F0F);
    idle();
    chk("R3 sp", 32'(sp_o), 1);
    step(0, 1, '0); #1;
    chk("R3 pop data2", 32'(pc_o), 32'h0ABCDE);
    idle();
    chk("R10 sp", 32'(sp_o), 0);
    chk("R10 empty pc", 32'(pc_o), 0);
    chk("R6 no unf", 32'(unf_o), 0);
  endtask

  task automatic t_deep();
    for (int i = 1; i <= DEPTH; i++) begin
      step(1, 0, val(i));
      if (i == DEPTH) begin
        #1; chk("R9 not full at 30", 32'(full_o), 0);
      end
    end
    idle();
    chk("R9 full at 31", 32'(full_o), 1);
    chk("R5 sp 31", 32'(sp_o), 31);
    step(1, 0, 21'h155555); idle();
    chk("R5 ovf", 32'(ovf_o), 1);
    chk("R5 sp held", 32'(sp_o), 31);
    chk("R5 top kept", 32'(pc_o), 32'(val(DEPTH)));
    for (int i = DEPTH; i >= 1; i--) begin
      step(0, 1, '0); #1;
      chk("R4 lifo", 32'(pc_o), 32'(val(i)));
    end
    idle();
    chk("R4 drained", 32'(sp_o), 0);
    chk("R9 not full", 32'(full_o), 0);
  endtask

  task automatic t_both();
    step(1, 1, 21'h012345); idle();
    chk("R7 sp", 32'(sp_o), 1);
    chk("R7 top", 32'(pc_o), 32'h012345);
    step(0, 1, '0); idle();
    chk("R7 back to 0", 32'(sp_o), 0);
  endtask

  task automatic t_under();
    step(0, 1, '0); #1;
    chk("R6 pc zero", 32'(pc_o), 0);
    idle();
    chk("R6 unf", 32'(unf_o), 1);
    chk("R6 sp", 32'(sp_o), 0);
    step(1, 0, 21'h00AAAA); step(0, 1, '0); idle();
    chk("R8 ovf sticky", 32'(ovf_o), 1);
    chk("R8 unf sticky", 32'(unf_o), 1);
    chk("R10 pc zero", 32'(pc_o), 0);
    apply_reset();
    chk("R8 ovf cleared", 32'(ovf_o), 0);
    chk("R8 unf cleared", 32'(unf_o), 0);
    chk("R1 sp after reset", 32'(sp_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; push_i = 1'b0; pop_i = 1'b0; pc_i = '0;
    apply_reset();
    t_reset();
    t_push_pop();
    t_deep();
    t_both();
    t_under();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule